// File: doc/BRIEF.md
# Pseudo-exhaustive constant-weight pattern generator

This block drives the collapsed test-signal inputs of a combinational circuit under test. After the circuit's inputs have been folded into `P_WIDTH` test signals, with no output depending on more than some number `w` of them, a short pattern set still exercises every output cone exhaustively. A build-time parameter picks the family that suits the relation between `P_WIDTH` and `w`: the full binary space when they are equal, one parity half of the space when `P_WIDTH` is one larger, or a single constant-weight code when it is larger still.

A run begins with a start pulse, which also latches the parity choice and the requested weight. While enable is high, one pattern leaves per clock with a valid strobe. Holding enable low stalls the run without losing its place. A one-cycle done pulse follows the final pattern, and the block then waits for the next start.

Top module: `pe_pattern_gen`

## Requirements
- R1: With the full family, a run emits all 2^P_WIDTH patterns in ascending binary order, from all zeros to all ones.
- R2: With the parity family, a run emits 2^(P_WIDTH-1) patterns. The upper P_WIDTH-1 bits count up from zero, and bit 0 is chosen so that the pattern has an odd number of ones when `odd_parity_i` was 1 at start, or an even number when it was 0.
- R3: With the weight family, a run emits every P_WIDTH-bit pattern whose number of ones equals the latched weight, in descending binary order (for P_WIDTH=4 and weight 2: 1100, 1010, 1001, 0110, 0101, 0011). A weight of 0 gives the single pattern of all zeros. A weight above P_WIDTH is treated as P_WIDTH.
- R4: A start seen while idle begins a run. Each clock edge during a run at which `enable_i` is high emits the next pattern, with `valid_o` high for the following cycle. With `enable_i` low, `valid_o` is low and `pattern_o` keeps its last value.
- R5: `done_o` is high for exactly one cycle, the cycle right after the last valid pattern, and never together with `valid_o`. The block then idles, and `valid_o` stays low until a new start.
- R6: `odd_parity_i` and `weight_i` are sampled only when a start is accepted. Changing them during a run does not alter that run's patterns.
- R7: A start pulse during a run, up to and including the cycle before done, is ignored. The run continues unchanged.
- R8: Asynchronous reset clears `pattern_o`, `valid_o` and `done_o` to 0 and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when idle; latches configuration |
| enable_i | input | 1 | Advances the run by one pattern per clock |
| odd_parity_i | input | 1 | Parity family: 1 selects odd, 0 selects even |
| weight_i | input | $clog2(P_WIDTH+1) | Weight family: number of ones per pattern |
| pattern_o | output | P_WIDTH | Current test pattern |
| valid_o | output | 1 | A new pattern is on `pattern_o` this cycle |
| done_o | output | 1 | One-cycle pulse after the last pattern |

## Verification
A start pulse can arrive in the same cycle as a pattern emission. The bench raises start in the middle of an enabled run, and the run must keep the same sequence and length, with done arriving after the expected final pattern. The parity and weight inputs can also change in the same cycle as an emission. The bench flips them mid-run, and every later pattern must still match the sequence computed from the values latched at start, with the checker confirming parity or weight on every valid cycle.

// File: rtl/pe_gen_pkg.sv
package pe_gen_pkg;

  typedef enum logic [1:0] {
    FAM_FULL   = 2'd0,
    FAM_PARITY = 2'd1,
    FAM_WEIGHT = 2'd2
  } fam_e;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RUN  = 2'd1,
    RS_FIN  = 2'd2
  } run_state_e;

endpackage

// File: rtl/pe_run_ctrl.sv
module pe_run_ctrl
  import pe_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic enable_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic valid_o,
  output logic done_o
);

  run_state_e state_q, state_d;
  logic       valid_q, done_q;

  assign load_o = (state_q == RS_IDLE) && start_i;
  assign step_o = (state_q == RS_RUN) && enable_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE: if (start_i) state_d = RS_RUN;
      RS_RUN:  if (enable_i && last_i) state_d = RS_FIN;
      RS_FIN:  state_d = RS_IDLE;
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= step_o;
      done_q  <= (state_q == RS_FIN);
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;

endmodule

// File: rtl/pe_seq_core.sv
module pe_seq_core
  import pe_gen_pkg::*;
#(
  parameter int   P_WIDTH = 4,
  parameter fam_e FAMILY  = FAM_WEIGHT,
  localparam int  KW      = $clog2(P_WIDTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               odd_i,
  input  logic [KW-1:0]      weight_i,
  output logic [P_WIDTH-1:0] pat_o,
  output logic               last_o
);

  if (FAMILY == FAM_FULL) begin : g_full
    logic [P_WIDTH-1:0] cnt_q;
    logic               unused_cfg;
    assign unused_cfg = ^{odd_i, weight_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (load_i) cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_q + 1'b1;
    end

    assign pat_o  = cnt_q;
    assign last_o = &cnt_q;

  end else if (FAMILY == FAM_PARITY) begin : g_parity
    logic [P_WIDTH-2:0] cnt_q;
    logic               odd_q;
    logic               unused_cfg;
    assign unused_cfg = ^weight_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        odd_q <= 1'b0;
      end else if (load_i) begin
        cnt_q <= '0;
        odd_q <= odd_i;
      end else if (step_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    // LSB fixes the total parity
    assign pat_o  = {cnt_q, (^cnt_q) ^ odd_q};
    assign last_o = &cnt_q;

  end else begin : g_weight
    // Track the complement: descending weight-k words are ascending weight-(P-k) words
    logic [P_WIDTH-1:0] y_q, c, r, t;
    logic [KW-1:0]      k_q, zk_q, k_ld, zk_ld;
    int                 kc;
    logic               unused_cfg;
    assign unused_cfg = odd_i;

    function automatic logic [P_WIDTH-1:0] low_ones(input logic [KW-1:0] n);
      logic [P_WIDTH-1:0] m;
      m = '0;
      for (int i = 0; i < P_WIDTH; i++) if (i < int'(n)) m[i] = 1'b1;
      return m;
    endfunction

    function automatic int trail_zeros(input logic [P_WIDTH-1:0] v);
      int n;
      n = 0;
      for (int i = P_WIDTH - 1; i >= 0; i--) if (v[i]) n = i;
      return n;
    endfunction

    always_comb begin
      if (int'(weight_i) > P_WIDTH) kc = P_WIDTH;
      else                          kc = int'(weight_i);
      k_ld  = KW'(kc);
      zk_ld = KW'(P_WIDTH - kc);
      c = y_q & (~y_q + 1'b1);
      r = y_q + c;
      t = (r ^ y_q) >> (trail_zeros(c) + 2);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        y_q  <= '1;
        k_q  <= '0;
        zk_q <= KW'(P_WIDTH);
      end else if (load_i) begin
        y_q  <= low_ones(zk_ld);
        k_q  <= k_ld;
        zk_q <= zk_ld;
      end else if (step_i) begin
        y_q <= r | t;
      end
    end

    assign pat_o  = ~y_q;
    assign last_o = (y_q == (low_ones(zk_q) << k_q));
  end

endmodule

// File: rtl/pe_pattern_gen.sv
module pe_pattern_gen
  import pe_gen_pkg::*;
#(
  parameter int   P_WIDTH = 4,
  parameter fam_e FAMILY  = FAM_WEIGHT
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           enable_i,
  input  logic                           odd_parity_i,
  input  logic [$clog2(P_WIDTH+1)-1:0]   weight_i,
  output logic [P_WIDTH-1:0]             pattern_o,
  output logic                           valid_o,
  output logic                           done_o
);

  logic               load, step, last;
  logic [P_WIDTH-1:0] core_pat, pattern_q;

  pe_run_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .enable_i (enable_i),
    .last_i   (last),
    .load_o   (load),
    .step_o   (step),
    .valid_o  (valid_o),
    .done_o   (done_o)
  );

  pe_seq_core #(
    .P_WIDTH (P_WIDTH),
    .FAMILY  (FAMILY)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .odd_i    (odd_parity_i),
    .weight_i (weight_i),
    .pat_o    (core_pat),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pattern_q <= '0;
    else if (step) pattern_q <= core_pat;
  end

  assign pattern_o = pattern_q;

endmodule

// File: rtl/pe_pattern_gen_chk.sv
module pe_pattern_gen_chk
  import pe_gen_pkg::*;
#(
  parameter int   P_WIDTH = 4,
  parameter fam_e FAMILY  = FAM_WEIGHT
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic                         enable_i,
  input logic                         odd_parity_i,
  input logic [$clog2(P_WIDTH+1)-1:0] weight_i,
  input logic [P_WIDTH-1:0]           pattern_o,
  input logic                         valid_o,
  input logic                         done_o
);

  logic busy_q, accept, odd_run;
  int   k_run;

  assign accept = start_i && (!busy_q || done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      odd_run <= 1'b0;
      k_run   <= 0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      odd_run <= odd_parity_i;
      k_run   <= (int'(weight_i) > P_WIDTH) ? P_WIDTH : int'(weight_i);
    end else if (done_o) begin
      busy_q  <= 1'b0;
    end
  end

  assert_valid_done_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && done_o));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_o));

  assert_hold_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pattern_o));

  assert_no_valid_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !accept) |=> !valid_o);

  if (FAMILY == FAM_WEIGHT) begin : g_w
    assert_descending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && $past(valid_o)) |-> (pattern_o < $past(pattern_o)));
    assert_weight_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ($countones(pattern_o) == k_run));
  end else if (FAMILY == FAM_PARITY) begin : g_p
    assert_ascending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && $past(valid_o)) |-> (pattern_o > $past(pattern_o)));
    assert_parity_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ((^pattern_o) == odd_run));
  end else begin : g_f
    assert_ascending_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && $past(valid_o)) |-> (pattern_o == $past(pattern_o) + 1'b1));
  end

endmodule

bind pe_pattern_gen pe_pattern_gen_chk #(
  .P_WIDTH (P_WIDTH),
  .FAMILY  (FAMILY)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .enable_i     (enable_i),
  .odd_parity_i (odd_parity_i),
  .weight_i     (weight_i),
  .pattern_o    (pattern_o),
  .valid_o      (valid_o),
  .done_o       (done_o)
);

// File: tb/pe_pattern_gen_test.sv
module pe_pattern_gen_test;
  import pe_gen_pkg::*;

  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable, odd;
  logic [2:0] weight;
  logic [2:0] start_v;
  logic [P-1:0] pat_f, pat_p, pat_w;
  logic val_f, val_p, val_w, done_f, done_p, done_w;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pe_pattern_gen #(.P_WIDTH(P), .FAMILY(FAM_FULL)) uut_full (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_v[0]), .enable_i(enable),
    .odd_parity_i(odd), .weight_i(weight), .pattern_o(pat_f), .valid_o(val_f), .done_o(done_f));

  pe_pattern_gen #(.P_WIDTH(P), .FAMILY(FAM_PARITY)) uut_par (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_v[1]), .enable_i(enable),
    .odd_parity_i(odd), .weight_i(weight), .pattern_o(pat_p), .valid_o(val_p), .done_o(done_p));

  pe_pattern_gen #(.P_WIDTH(P), .FAMILY(FAM_WEIGHT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_v[2]), .enable_i(enable),
    .odd_parity_i(odd), .weight_i(weight), .pattern_o(pat_w), .valid_o(val_w), .done_o(done_w));

  function automatic logic [P-1:0] cur_pat(int fam);
    case (fam)
      0: return pat_f;
      1: return pat_p;
      default: return pat_w;
    endcase
  endfunction

  function automatic logic cur_val(int fam);
    case (fam)
      0: return val_f;
      1: return val_p;
      default: return val_w;
    endcase
  endfunction

  function automatic logic cur_done(int fam);
    case (fam)
      0: return done_f;
      1: return done_p;
      default: return done_w;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // One run on instance fam; expected sequence is built here from the requirements.
  task automatic run_case(input int fam, input logic odd_in, input int k_in,
                          input bit stall, input bit poke, input bit flip, input string req);
    logic [P-1:0] exp_q[$];
    int idx, cyc, kk;
    bit en_now;
    exp_q.delete();
    if (fam == 0) begin
      for (int i = 0; i < (1 << P); i++) exp_q.push_back(P'(i));
    end else if (fam == 1) begin
      for (int i = 0; i < (1 << (P - 1)); i++) begin
        logic [P-2:0] u;
        u = (P-1)'(i);
        exp_q.push_back({u, (^u) ^ odd_in});
      end
    end else begin
      kk = (k_in > P) ? P : k_in;
      for (int v = (1 << P) - 1; v >= 0; v--)
        if ($countones(P'(v)) == kk) exp_q.push_back(P'(v));
    end

    @(negedge clk);
    odd = odd_in;
    weight = 3'(k_in);
    enable = 1'b0;
    start_v = 3'b000;
    start_v[fam] = 1'b1;
    @(negedge clk);
    start_v = 3'b000;

    idx = 0;
    cyc = 0;
    while (idx < exp_q.size() && cyc < 200) begin
      en_now = stall ? ((cyc % 3) != 1) : 1'b1;
      enable = en_now;
      start_v = 3'b000;
      if (poke && (cyc == 3 || cyc == 5)) start_v[fam] = 1'b1;  // R7
      if (flip && cyc == 3) begin  // R6
        odd = ~odd;
        weight = weight + 3'd1;
      end
      @(negedge clk);
      cyc++;
      if (en_now) begin
        chk(cur_val(fam) == 1'b1, req, "valid on step", int'(cur_val(fam)), 1);
        chk(cur_pat(fam) == exp_q[idx], req, $sformatf("pattern %0d", idx),
            int'(cur_pat(fam)), int'(exp_q[idx]));
        chk(cur_done(fam) == 1'b0, "R5", "done during run", int'(cur_done(fam)), 0);
        idx++;
      end else begin
        chk(cur_val(fam) == 1'b0, "R4", "valid during stall", int'(cur_val(fam)), 0);
        if (idx > 0)
          chk(cur_pat(fam) == exp_q[idx-1], "R4", "pattern held in stall",
              int'(cur_pat(fam)), int'(exp_q[idx-1]));
      end
    end
    start_v = 3'b000;
    enable = 1'b1;
    @(negedge clk);
    chk(cur_done(fam) == 1'b1, "R5", "done after last", int'(cur_done(fam)), 1);
    chk(cur_val(fam) == 1'b0, "R5", "valid with done", int'(cur_val(fam)), 0);
    @(negedge clk);
    chk(cur_done(fam) == 1'b0, "R5", "done single cycle", int'(cur_done(fam)), 0);
    chk(cur_val(fam) == 1'b0, "R5", "idle after done", int'(cur_val(fam)), 0);
    @(negedge clk);
    chk(cur_val(fam) == 1'b0, "R5", "still idle", int'(cur_val(fam)), 0);
    enable = 1'b0;
  endtask

  task automatic test_reset();
    chk(pat_f == '0 && pat_p == '0 && pat_w == '0, "R8", "pattern after reset",
        int'(pat_f | pat_p | pat_w), 0);
    chk(!val_f && !val_p && !val_w, "R8", "valid after reset", int'(val_f | val_p | val_w), 0);
    chk(!done_f && !done_p && !done_w, "R8", "done after reset", int'(done_f | done_p | done_w), 0);
  endtask

  task automatic test_full();        run_case(0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1"); endtask
  task automatic test_parity_odd();  run_case(1, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R2"); endtask
  task automatic test_parity_even(); run_case(1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R2"); endtask
  task automatic test_weight2();     run_case(2, 1'b0, 2, 1'b0, 1'b0, 1'b0, "R3"); endtask
  task automatic test_weight0();     run_case(2, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R3"); endtask
  task automatic test_weight_full(); run_case(2, 1'b0, 4, 1'b0, 1'b0, 1'b0, "R3"); endtask
  task automatic test_weight_clamp();run_case(2, 1'b0, 7, 1'b0, 1'b0, 1'b0, "R3"); endtask
  task automatic test_stall();       run_case(2, 1'b0, 1, 1'b1, 1'b0, 1'b0, "R4"); endtask
  task automatic test_cfg_par();     run_case(1, 1'b1, 0, 1'b0, 1'b0, 1'b1, "R6"); endtask
  task automatic test_cfg_w();       run_case(2, 1'b0, 3, 1'b1, 1'b0, 1'b1, "R6"); endtask
  task automatic test_start_ignored();run_case(0, 1'b0, 0, 1'b1, 1'b1, 1'b0, "R7"); endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    enable = 1'b0;
    odd = 1'b0;
    weight = 3'd0;
    start_v = 3'b000;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_full();
    test_parity_odd();
    test_parity_even();
    test_weight2();
    test_weight0();
    test_weight_full();
    test_weight_clamp();
    test_stall();
    test_cfg_par();
    test_cfg_w();
    test_start_ignored();
    summary();
    $finish;
  end

endmodule